// File: doc/BRIEF.md
# Row-Buffer Victim Tracker

This block watches the stream of row addresses presented to a DRAM bank and classifies each access against a single open-row register and a small victim store of rows that were recently closed. An access that matches the open row is a main hit. An access that matches a row in the victim store is a victim hit, reported together with its depth, where depth 1 is the row closed most recently. An access that matches neither is a total miss. The store holds only row addresses; no data is kept.

Whenever an access does not hit the open row, the row that was open is pushed onto the top of the victim store and the accessed row becomes the open row. On a victim hit the matching entry is taken out of the store, so the store never holds a duplicate. On a total miss with a full store, the oldest entry falls off the bottom. Separate counters record main hits, total misses and hits at each depth. A free-running cycle count is stamped onto the top entry when it is pushed, so that a hit at depth 1 reports how many cycles passed since that row was displaced.

Top module: `row_victim_tracker`

## Requirements
- R1: After reset, res_valid is 0, res_kind is 0 (idle), res_depth is 0, gap_valid is 0 and every counter reads 0.
- R2: An access whose row equals the open row reports res_kind 1 (main hit) with res_depth 0, adds one to cnt_main, and leaves the open row and the victim store unchanged.
- R3: An access whose row matches a stored victim reports res_kind 2 and res_depth equal to the entry's position, 1 being the most recently displaced row and DEPTH the oldest.
- R4: On a victim hit, the matching entry is removed, the entries above it move down one place, the previously open row takes the top place, and the accessed row becomes the open row.
- R5: An access matching neither the open row nor any victim reports res_kind 3; the open row is pushed on top, every entry moves down one place, the entry at depth DEPTH is discarded when the store is full, and the accessed row becomes the open row.
- R6: The first access after reset is a total miss that only loads the open row and pushes nothing into the store.
- R7: cnt_main, cnt_miss and the DEPTH depth counters (depth d in bits [(d-1)*CNT_W +: CNT_W] of cnt_depth) each count their events and, when SATURATE is set, hold at 2^CNT_W-1.
- R8: A victim hit at depth 1 raises gap_valid and puts on gap_cycles the number of clock cycles between the access that displaced that row and this access; gap_valid is 0 for every other result.
- R9: Results and counters of an access sampled on a clock edge are visible right after that edge; a cycle with acc_valid low yields res_valid 0 and res_kind 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_row | input | ROW_W | Row address of the access |
| res_valid | output | 1 | Result fields describe the access of the previous cycle |
| res_kind | output | 2 | 0 idle, 1 main hit, 2 victim hit, 3 total miss |
| res_depth | output | DEPTH_W | Victim depth 1..DEPTH, 0 otherwise |
| gap_valid | output | 1 | gap_cycles is meaningful (depth-1 hit) |
| gap_cycles | output | TS_W | Cycles since the hit row was displaced |
| cnt_main | output | CNT_W | Main-hit counter |
| cnt_miss | output | CNT_W | Total-miss counter |
| cnt_depth | output | DEPTH*CNT_W | Per-depth victim-hit counters, depth 1 in the low slice |

## Verification
Every result field and every counter of an access is due exactly one clock edge after the access is sampled, since a single register stage sits between the comparison and the outputs. The bench presents each access on a falling edge and reads the outputs on the following falling edge, so the single rising edge between them is the one that registers the result. The gap expectation is built from the bench's own edge count taken at the displacing access and at the re-referencing access, and back-to-back accesses are used so that a gap of one cycle is covered.

// File: rtl/vrt_pkg.sv
package vrt_pkg;

   typedef enum logic [1:0] {
      VK_IDLE   = 2'd0,
      VK_MAIN   = 2'd1,
      VK_VICTIM = 2'd2,
      VK_MISS   = 2'd3
   } vrt_kind_e;

endpackage

// File: rtl/vrt_match.sv
module vrt_match #(
   parameter int ROW_W = 14,
   parameter int DEPTH = 8
) (
   input  logic [ROW_W-1:0]       row,
   input  logic [ROW_W-1:0]       open_row,
   input  logic                   open_valid,
   input  logic [DEPTH*ROW_W-1:0] store_rows,
   input  logic [DEPTH-1:0]       store_valid,
   output logic                   main_hit,
   output logic [DEPTH-1:0]       hit_vec
);

   assign main_hit = open_valid && (open_row == row);

   for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      assign hit_vec[i] = store_valid[i] && (store_rows[i*ROW_W +: ROW_W] == row);
   end

endmodule

// File: rtl/vrt_store.sv
module vrt_store #(
   parameter int ROW_W = 14,
   parameter int DEPTH = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   push,
   input  logic [ROW_W-1:0]       push_row,
   input  logic [DEPTH-1:0]       hit_vec,
   output logic [DEPTH*ROW_W-1:0] rows,
   output logic [DEPTH-1:0]       valid
);

   logic [ROW_W-1:0] ent   [DEPTH];
   logic [DEPTH-1:0] below;

   // below[i]: the removed entry sits above slot i, so slot i keeps its content
   assign below[0] = 1'b0;
   for (genvar i = 1; i < DEPTH; i++) begin : g_pref
      assign below[i] = below[i-1] | hit_vec[i-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent[0]   <= '0;
         valid[0] <= 1'b0;
      end else if (push) begin
         ent[0]   <= push_row;
         valid[0] <= 1'b1;
      end
   end

   for (genvar i = 1; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent[i]   <= '0;
            valid[i] <= 1'b0;
         end else if (push && !below[i]) begin
            ent[i]   <= ent[i-1];
            valid[i] <= valid[i-1];
         end
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_out
      assign rows[i*ROW_W +: ROW_W] = ent[i];
   end

endmodule

// File: rtl/vrt_counters.sv
module vrt_counters #(
   parameter int N        = 10,
   parameter int CNT_W    = 32,
   parameter bit SATURATE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N-1:0]       inc,
   output logic [N*CNT_W-1:0] cnt
);

   for (genvar i = 0; i < N; i++) begin : g_cnt
      logic [CNT_W-1:0] c;
      if (SATURATE) begin : g_sat
         always_ff @(posedge clk) begin
            if (!rst_n)                   c <= '0;
            else if (inc[i] && (c != '1)) c <= c + 1'b1;
         end
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (!rst_n)      c <= '0;
            else if (inc[i]) c <= c + 1'b1;
         end
      end
      assign cnt[i*CNT_W +: CNT_W] = c;
   end

endmodule

// File: rtl/row_victim_tracker.sv
module row_victim_tracker
   import vrt_pkg::*;
#(
   parameter int ROW_W    = 14,
   parameter int DEPTH    = 8,
   parameter int CNT_W    = 32,
   parameter int TS_W     = 32,
   parameter bit SATURATE = 1'b1,
   parameter int DEPTH_W  = $clog2(DEPTH + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   acc_valid,
   input  logic [ROW_W-1:0]       acc_row,
   output logic                   res_valid,
   output logic [1:0]             res_kind,
   output logic [DEPTH_W-1:0]     res_depth,
   output logic                   gap_valid,
   output logic [TS_W-1:0]        gap_cycles,
   output logic [CNT_W-1:0]       cnt_main,
   output logic [CNT_W-1:0]       cnt_miss,
   output logic [DEPTH*CNT_W-1:0] cnt_depth
);

   localparam int NCNT = DEPTH + 2;

   if (DEPTH < 2 || DEPTH > 32) begin : g_bad_depth
      $error("row_victim_tracker: DEPTH must lie in 2..32");
   end
   if (ROW_W < 1) begin : g_bad_row
      $error("row_victim_tracker: ROW_W must be positive");
   end
   if (CNT_W < 2 || TS_W < 2) begin : g_bad_cnt
      $error("row_victim_tracker: CNT_W and TS_W must be at least 2");
   end
   if (DEPTH_W < $clog2(DEPTH + 1)) begin : g_bad_dw
      $error("row_victim_tracker: DEPTH_W too narrow for DEPTH");
   end

   logic [ROW_W-1:0]       open_row;
   logic                   open_valid;
   logic [TS_W-1:0]        cyc;
   logic [TS_W-1:0]        ts_top;
   logic [DEPTH*ROW_W-1:0] store_rows;
   logic [DEPTH-1:0]       store_valid;
   logic                   main_hit;
   logic [DEPTH-1:0]       hit_vec;
   logic                   acc_main, acc_vic, acc_miss, push;
   logic [DEPTH_W-1:0]     hit_depth;
   logic [NCNT-1:0]        inc;
   logic [NCNT*CNT_W-1:0]  cnt_all;
   vrt_kind_e              kind_d, kind_q;

   vrt_match #(.ROW_W(ROW_W), .DEPTH(DEPTH)) u_match (
      .row        (acc_row),
      .open_row   (open_row),
      .open_valid (open_valid),
      .store_rows (store_rows),
      .store_valid(store_valid),
      .main_hit   (main_hit),
      .hit_vec    (hit_vec)
   );

   assign acc_main = acc_valid && main_hit;
   assign acc_vic  = acc_valid && !main_hit && (|hit_vec);
   assign acc_miss = acc_valid && !main_hit && !(|hit_vec);
   assign push     = (acc_vic || acc_miss) && open_valid;

   always_comb begin
      hit_depth = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (hit_vec[i]) hit_depth = DEPTH_W'(i + 1);
      end
   end

   always_comb begin
      if (acc_main)     kind_d = VK_MAIN;
      else if (acc_vic) kind_d = VK_VICTIM;
      else if (acc_miss) kind_d = VK_MISS;
      else              kind_d = VK_IDLE;
   end

   vrt_store #(.ROW_W(ROW_W), .DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (push),
      .push_row(open_row),
      .hit_vec (hit_vec),
      .rows    (store_rows),
      .valid   (store_valid)
   );

   assign inc[0]      = acc_main;
   assign inc[1]      = acc_miss;
   assign inc[NCNT-1:2] = acc_vic ? hit_vec : '0;

   vrt_counters #(.N(NCNT), .CNT_W(CNT_W), .SATURATE(SATURATE)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (inc),
      .cnt  (cnt_all)
   );

   assign cnt_main  = cnt_all[0 +: CNT_W];
   assign cnt_miss  = cnt_all[CNT_W +: CNT_W];
   assign cnt_depth = cnt_all[2*CNT_W +: DEPTH*CNT_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_row   <= '0;
         open_valid <= 1'b0;
         cyc        <= '0;
         ts_top     <= '0;
         kind_q     <= VK_IDLE;
         res_valid  <= 1'b0;
         res_depth  <= '0;
         gap_valid  <= 1'b0;
         gap_cycles <= '0;
      end else begin
         cyc       <= cyc + 1'b1;
         kind_q    <= kind_d;
         res_valid <= acc_valid;
         res_depth <= acc_vic ? hit_depth : '0;
         gap_valid <= acc_vic && hit_vec[0];
         if (acc_vic && hit_vec[0]) gap_cycles <= cyc - ts_top;
         if (push) ts_top <= cyc;
         if (acc_vic || acc_miss) begin
            open_row   <= acc_row;
            open_valid <= 1'b1;
         end
      end
   end

   assign res_kind = kind_q;

endmodule

// File: rtl/row_victim_tracker_chk.sv
module row_victim_tracker_chk #(
   parameter int ROW_W    = 14,
   parameter int DEPTH    = 8,
   parameter int CNT_W    = 32,
   parameter int DEPTH_W  = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               acc_valid,
   input logic               res_valid,
   input logic [1:0]         res_kind,
   input logic [DEPTH_W-1:0] res_depth,
   input logic               gap_valid,
   input logic [CNT_W-1:0]   cnt_main,
   input logic [CNT_W-1:0]   cnt_miss,
   input logic [DEPTH-1:0]   hit_vec
);

   localparam logic [CNT_W-1:0] CMAX = '1;

   AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec)); // R3
   AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> res_valid); // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> (!res_valid && res_kind == 2'd0)); // R9
   AST_DEPTH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_kind == 2'd2) |-> (res_depth >= 1 && res_depth <= DEPTH_W'(DEPTH))); // R3
   AST_DEPTH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (res_kind != 2'd2) |-> (res_depth == '0)); // R2
   AST_GAP_TOP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      gap_valid |-> (res_kind == 2'd2 && res_depth == DEPTH_W'(1))); // R8
   AST_MAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (res_kind == 2'd1 && $past(cnt_main) != CMAX) |-> (cnt_main == $past(cnt_main) + 1'b1)); // R7
   AST_MAIN_KEEPS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (res_kind == 2'd1) |-> $stable(cnt_miss)); // R2
   AST_MISS_KEEPS_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (res_kind == 2'd3) |-> $stable(cnt_main)); // R5

endmodule

bind row_victim_tracker row_victim_tracker_chk #(
   .ROW_W  (ROW_W),
   .DEPTH  (DEPTH),
   .CNT_W  (CNT_W),
   .DEPTH_W(DEPTH_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .acc_valid(acc_valid),
   .res_valid(res_valid),
   .res_kind (res_kind),
   .res_depth(res_depth),
   .gap_valid(gap_valid),
   .cnt_main (cnt_main),
   .cnt_miss (cnt_miss),
   .hit_vec  (hit_vec)
);

// File: tb/row_victim_tracker_test.sv
module row_victim_tracker_test;

   localparam int ROW_W = 8;
   localparam int DEPTH = 8;
   localparam int CNT_W = 6;
   localparam int TS_W  = 32;
   localparam int DW    = $clog2(DEPTH + 1);
   localparam int CMAX  = (1 << CNT_W) - 1;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic                   acc_valid = 1'b0;
   logic [ROW_W-1:0]       acc_row = '0;
   logic                   res_valid;
   logic [1:0]             res_kind;
   logic [DW-1:0]          res_depth;
   logic                   gap_valid;
   logic [TS_W-1:0]        gap_cycles;
   logic [CNT_W-1:0]       cnt_main, cnt_miss;
   logic [DEPTH*CNT_W-1:0] cnt_depth;

   always #5 clk = ~clk;

   row_victim_tracker #(.ROW_W(ROW_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .TS_W(TS_W)) uut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_row(acc_row),
      .res_valid(res_valid), .res_kind(res_kind), .res_depth(res_depth),
      .gap_valid(gap_valid), .gap_cycles(gap_cycles),
      .cnt_main(cnt_main), .cnt_miss(cnt_miss), .cnt_depth(cnt_depth)
   );

   int checks = 0;
   int errors = 0;
   int edges  = 0;
   bit done   = 1'b0;

   logic [ROW_W-1:0] m_open;
   bit               m_open_v;
   logic [ROW_W-1:0] m_f [DEPTH];
   int               m_n, m_ts, c_main, c_miss;
   int               c_dep [DEPTH];

   function automatic int sat_inc(int v);
      return (v < CMAX) ? v + 1 : v;
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic check_counters();
      check("R7 main counter", 64'(cnt_main), 64'(c_main));
      check("R7 miss counter", 64'(cnt_miss), 64'(c_miss));
      for (int d = 0; d < DEPTH; d++)
         check("R7 depth counter", 64'(cnt_depth[d*CNT_W +: CNT_W]), 64'(c_dep[d]));
   endtask

   // called at a falling edge; returns at the next falling edge with the result checked
   task automatic access(input logic [ROW_W-1:0] row, input string tag);
      int e, ek, ed, eg, egap, j;
      e = edges + 1;
      acc_valid = 1'b1;
      acc_row   = row;
      ed = 0; eg = 0; egap = 0; j = -1;
      if (m_open_v && m_open == row) begin
         ek = 1;
         c_main = sat_inc(c_main);
      end else begin
         for (int i = m_n - 1; i >= 0; i--) if (m_f[i] == row) j = i;
         if (j >= 0) begin
            ek = 2; ed = j + 1;
            if (j == 0) begin eg = 1; egap = e - m_ts; end
            for (int i = j; i > 0; i--) m_f[i] = m_f[i-1];
            m_f[0] = m_open; m_ts = e;
            c_dep[j] = sat_inc(c_dep[j]);
         end else begin
            ek = 3;
            if (m_open_v) begin
               for (int i = DEPTH - 1; i > 0; i--) m_f[i] = m_f[i-1];
               m_f[0] = m_open; m_ts = e;
               if (m_n < DEPTH) m_n++;
            end
            c_miss = sat_inc(c_miss);
         end
         m_open = row; m_open_v = 1'b1;
      end
      @(negedge clk);
      edges = e;
      check("R9 result valid", 64'(res_valid), 64'd1);
      check(tag, 64'(res_kind), 64'(ek));
      check("R3 depth", 64'(res_depth), 64'(ed));
      check("R8 gap flag", 64'(gap_valid), 64'(eg));
      if (eg != 0) check("R8 gap cycles", 64'(gap_cycles), 64'(egap));
      check_counters();
   endtask

   task automatic idle();
      acc_valid = 1'b0;
      @(negedge clk);
      edges++;
      check("R9 idle valid", 64'(res_valid), 64'd0);
      check("R9 idle kind", 64'(res_kind), 64'd0);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL R9 watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      m_open = '0; m_open_v = 1'b0; m_n = 0; m_ts = 0; c_main = 0; c_miss = 0;
      for (int i = 0; i < DEPTH; i++) begin m_f[i] = '0; c_dep[i] = 0; end

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R1 reset valid", 64'(res_valid), 64'd0);
      check("R1 reset kind", 64'(res_kind), 64'd0);
      check("R1 reset depth", 64'(res_depth), 64'd0);
      check("R1 reset gap", 64'(gap_valid), 64'd0);
      check("R1 reset main", 64'(cnt_main), 64'd0);
      check("R1 reset miss", 64'(cnt_miss), 64'd0);
      check("R1 reset depths", 64'(|cnt_depth), 64'd0);

      // directed corner cases
      access(8'd5, "R6 first access miss");
      access(8'd5, "R2 main hit");
      access(8'd6, "R5 miss pushes open");
      access(8'd5, "R8 back-to-back depth1 hit");
      idle();
      idle();
      access(8'd6, "R8 depth1 hit after idle");
      for (int r = 100; r < 109; r++) access(8'(r), "R5 fill store");
      access(8'd5, "R5 oldest discarded");
      access(8'd101, "R3 deepest entry");
      access(8'd104, "R4 middle entry removed");
      access(8'd101, "R4 reordered entry");
      access(8'd104, "R4 displaced open on top");
      idle();

      // random phase: small row pool for frequent hits; counters saturate at CMAX
      for (int n = 0; n < 3000; n++) begin
         if ($urandom_range(0, 4) == 0) idle();
         else access(8'($urandom_range(0, 11)), "R5 random kind");
      end
      check("R7 main saturated", 64'(cnt_main), 64'(CMAX));
      idle();

      done = 1'b1;
      summary();
      $finish;
   end

endmodule